// File: doc/BRIEF.md
# Upper Memory Shadow Route Decoder

This block classifies every memory address in the 0xC0000 to 0xFFFFF upper window. For each address it gives one route for reads and one for writes. A route is one of four targets: internal DRAM (the shadow copy), the external ROM chip-select, the external bus, or blocked. Blocked applies to writes only. The decision comes from configuration fields that describe which segments are shadowed, which ROM ranges own a chip-select, and which ranges are write-locked. The block is purely combinational, so a memory controller can sample the routes in the same cycle that it presents the address.

The window is split into pieces of two sizes. The lower half has eight 16 KB segments, and each one has its own read-enable bit and write-enable bit. The upper half has coarser regions: two 32 KB halves of 0xE0000 to 0xEFFFF that share one shadow pair, and a 64 KB region at 0xF0000 to 0xFFFFF. From the same fields the block also reports how much top-of-memory DRAM may be relocated above the physical top. Relocation is only allowed when the shadow segments that would overlap it are all unused.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level, and the outputs follow the inputs with no back-pressure and no latency.

Top module: `shadow_route_decoder`

## Requirements
- R1: Any address below 0xC0000 or above 0xFFFFF routes both reads and writes to internal DRAM. The route codes are 00 internal, 01 ROM chip-select, 10 external bus and 11 blocked.
- R2: For segment s (0..7) at 0xC0000 + s×16 KB, the shadow pair is taken from `seg_ctl_lo` for s<4 and from `seg_ctl_hi` for s≥4, at bit position (s mod 4)×2. The even bit of the pair enables internal writes and the odd bit enables internal reads. An enabled direction routes to 00.
- R3: In 0xC0000 to 0xC7FFF, a direction that is not shadowed routes to 01 when `rom_sel[2]` is set and to 10 when it is clear.
- R4: When `wr_lock[2]` is set, writes in 0xC0000 to 0xC7FFF route to 11 even if write shadowing is enabled. Reads in that range are unaffected.
- R5: In 0xC8000 to 0xCFFFF, a direction that is not shadowed routes to 01 when `rom_sel[3]` is set and to 10 otherwise. No lock applies to this range.
- R6: In 0xD0000 to 0xDFFFF, a direction that is not shadowed always routes to 10.
- R7: In 0xE0000 to 0xEFFFF, `bios_ctl[3]` enables internal reads and `bios_ctl[2]` enables internal writes. A direction that is not shadowed routes to 01 when `rom_sel[0]` is set (for 0xE0000 to 0xE7FFF) or `rom_sel[1]` is set (for 0xE8000 to 0xEFFFF), and to 10 otherwise.
- R8: In 0xF0000 to 0xFFFFF, `bios_ctl[1]` enables internal reads and `bios_ctl[0]` enables internal writes. A direction that is not shadowed routes to 10.
- R9: `wr_lock[0]` blocks writes (code 11) in 0xE0000 to 0xEFFFF, and `wr_lock[1]` blocks writes in 0xF0000 to 0xFFFFF. A lock has priority over write shadowing and does not change reads.
- R10: `reloc_size` is computed from `reloc_mode`. Mode 2 gives 01 (256 KB) when `seg_ctl_hi` and `bios_ctl` are all zero. Mode 3 gives 10 (384 KB) when `seg_ctl_lo`, `seg_ctl_hi` and `bios_ctl` are all zero. Every other case gives 00.
- R11: The read route is never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | ADDR_W (24) | Byte address of the access |
| seg_ctl_lo | input | 8 | Shadow pairs for segments 0..3 (0xC0000 to 0xCFFFF) |
| seg_ctl_hi | input | 8 | Shadow pairs for segments 4..7 (0xD0000 to 0xDFFFF) |
| bios_ctl | input | 4 | [3:2] E region read/write shadow, [1:0] F region read/write shadow |
| rom_sel | input | 4 | ROM chip-select enables: [0] E0-E7, [1] E8-EF, [2] C0-C7, [3] C8-CF |
| wr_lock | input | 3 | Write locks: [0] E region, [1] F region, [2] C0-C7 |
| reloc_mode | input | 2 | Relocation request: 2 = 256 KB, 3 = 384 KB, other = none |
| rd_route | output | 2 | Read route code |
| wr_route | output | 2 | Write route code |
| reloc_size | output | 2 | Granted relocation: 00 none, 01 256 KB, 10 384 KB |

## Verification
The routes are swept at the start and end of every 16 KB block from 0xB0000 to 0x10FFFF. This is repeated under several hundred pseudo-random configurations, which are often forced sparse so that both the granted and the denied relocation cases occur. The start/end probes separate segment boundaries from off-by-one decodes. The random configurations separate the read and write bits of each pair and the individual ROM enables. Directed patterns set a lock together with write shadowing to show the lock's priority. Single set bits in `seg_ctl_lo` and in `seg_ctl_hi` show that 384 KB relocation is refused while 256 KB relocation tolerates the lower segments.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;
  typedef enum logic [1:0] {
    ROUTE_DRAM    = 2'b00,
    ROUTE_ROMCS   = 2'b01,
    ROUTE_EXTBUS  = 2'b10,
    ROUTE_BLOCKED = 2'b11
  } route_e;

  typedef enum logic [1:0] {
    RELOC_NONE = 2'b00,
    RELOC_256K = 2'b01,
    RELOC_384K = 2'b10
  } reloc_e;

  typedef struct packed {
    logic shd_wr;
    logic shd_rd;
    logic lock;
    logic rom_en;
  } slot_ctl_t;

  localparam int SMALL_SLOTS = 8;
  localparam int LARGE_SLOTS = 3;
  localparam int NUM_SLOTS   = SMALL_SLOTS + LARGE_SLOTS;
endpackage

// File: rtl/shadow_slot_decode.sv
module shadow_slot_decode #(
  parameter int ADDR_W = 24,
  parameter int SLOTS  = shadow_route_pkg::NUM_SLOTS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SLOTS-1:0]  slot_hit
);
  localparam int IDX_W = $clog2(SLOTS);

  logic             upper_zero;
  logic             in_win;
  logic [IDX_W-1:0] idx;

  generate
    if (ADDR_W > 20) begin : g_upper
      assign upper_zero = ~|addr[ADDR_W-1:20];
    end else begin : g_noupper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign in_win = upper_zero && (addr[19:18] == 2'b11);

  always_comb begin
    if (!addr[17])      idx = IDX_W'(addr[16:14]);
    else if (!addr[16]) idx = IDX_W'(8 + int'(addr[15]));
    else                idx = IDX_W'(10);
  end

  generate
    for (genvar k = 0; k < SLOTS; k++) begin : g_hit
      assign slot_hit[k] = in_win && (idx == IDX_W'(k));
    end
  endgenerate

  always_comb begin
    if (!$isunknown(addr)) begin
      // R1
      single_slot_chk: assert ($onehot0(slot_hit));
    end
  end
endmodule

// File: rtl/shadow_route_sel.sv
module shadow_route_sel
  import shadow_route_pkg::*;
(
  input  slot_ctl_t ctl,
  output route_e    rd,
  output route_e    wr
);
  route_e fallback;

  always_comb begin
    fallback = ctl.rom_en ? ROUTE_ROMCS : ROUTE_EXTBUS;
    rd = ctl.shd_rd ? ROUTE_DRAM : fallback;
    if (ctl.lock)        wr = ROUTE_BLOCKED;
    else if (ctl.shd_wr) wr = ROUTE_DRAM;
    else                 wr = fallback;
  end

  always_comb begin
    if (!$isunknown(ctl)) begin
      // R4
      lock_blocks_chk: assert (!ctl.lock || wr == ROUTE_BLOCKED);
      // R2
      shadow_write_chk: assert (ctl.lock || !ctl.shd_wr || wr == ROUTE_DRAM);
      // R3
      rom_fallback_chk: assert (ctl.shd_rd || (rd == ROUTE_ROMCS) == ctl.rom_en);
    end
  end
endmodule

// File: rtl/shadow_reloc_calc.sv
module shadow_reloc_calc
  import shadow_route_pkg::*;
(
  input  logic [7:0] seg_ctl_lo,
  input  logic [7:0] seg_ctl_hi,
  input  logic [3:0] bios_ctl,
  input  logic [1:0] reloc_mode,
  output reloc_e     reloc_size
);
  logic outer_free;
  logic all_free;

  assign outer_free = (seg_ctl_hi == 8'h00) && (bios_ctl == 4'h0);
  assign all_free   = outer_free && (seg_ctl_lo == 8'h00);

  always_comb begin
    unique case (reloc_mode)
      2'd2:    reloc_size = outer_free ? RELOC_256K : RELOC_NONE;
      2'd3:    reloc_size = all_free   ? RELOC_384K : RELOC_NONE;
      default: reloc_size = RELOC_NONE;
    endcase
  end

  always_comb begin
    if (!$isunknown({seg_ctl_lo, seg_ctl_hi, bios_ctl, reloc_mode})) begin
      // R10
      reloc_guard_chk: assert (reloc_size == RELOC_NONE ||
                               (seg_ctl_hi == 8'h00 && bios_ctl == 4'h0));
      // R10
      reloc_full_chk: assert (reloc_size != RELOC_384K || seg_ctl_lo == 8'h00);
    end
  end
endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        seg_ctl_lo,
  input  logic [7:0]        seg_ctl_hi,
  input  logic [3:0]        bios_ctl,
  input  logic [3:0]        rom_sel,
  input  logic [2:0]        wr_lock,
  input  logic [1:0]        reloc_mode,
  output logic [1:0]        rd_route,
  output logic [1:0]        wr_route,
  output logic [1:0]        reloc_size
);
  localparam int SLOTS = NUM_SLOTS;

  logic [SLOTS-1:0] slot_hit;
  slot_ctl_t        ctl    [SLOTS];
  route_e           rd_arr [SLOTS];
  route_e           wr_arr [SLOTS];
  route_e           rd_sel;
  route_e           wr_sel;
  reloc_e           reloc_w;

  shadow_slot_decode #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_decode (
    .addr     (addr),
    .slot_hit (slot_hit)
  );

  generate
    for (genvar s = 0; s < SMALL_SLOTS; s++) begin : g_small
      localparam int BP = (s % 4) * 2;
      if (s < 4) begin : g_lo
        assign ctl[s].shd_wr = seg_ctl_lo[BP];
        assign ctl[s].shd_rd = seg_ctl_lo[BP+1];
      end else begin : g_hi
        assign ctl[s].shd_wr = seg_ctl_hi[BP];
        assign ctl[s].shd_rd = seg_ctl_hi[BP+1];
      end
      if (s < 2) begin : g_c0
        assign ctl[s].lock   = wr_lock[2];
        assign ctl[s].rom_en = rom_sel[2];
      end else if (s < 4) begin : g_c8
        assign ctl[s].lock   = 1'b0;
        assign ctl[s].rom_en = rom_sel[3];
      end else begin : g_d
        assign ctl[s].lock   = 1'b0;
        assign ctl[s].rom_en = 1'b0;
      end
    end

    for (genvar e = 0; e < 2; e++) begin : g_e
      assign ctl[SMALL_SLOTS+e].shd_wr = bios_ctl[2];
      assign ctl[SMALL_SLOTS+e].shd_rd = bios_ctl[3];
      assign ctl[SMALL_SLOTS+e].lock   = wr_lock[0];
      assign ctl[SMALL_SLOTS+e].rom_en = rom_sel[e];
    end

    assign ctl[SLOTS-1].shd_wr = bios_ctl[0];
    assign ctl[SLOTS-1].shd_rd = bios_ctl[1];
    assign ctl[SLOTS-1].lock   = wr_lock[1];
    assign ctl[SLOTS-1].rom_en = 1'b0;

    for (genvar k = 0; k < SLOTS; k++) begin : g_sel
      shadow_route_sel u_sel (
        .ctl (ctl[k]),
        .rd  (rd_arr[k]),
        .wr  (wr_arr[k])
      );
    end
  endgenerate

  always_comb begin
    rd_sel = ROUTE_DRAM;
    wr_sel = ROUTE_DRAM;
    for (int k = 0; k < SLOTS; k++) begin
      if (slot_hit[k]) begin
        rd_sel = rd_arr[k];
        wr_sel = wr_arr[k];
      end
    end
  end

  shadow_reloc_calc u_reloc (
    .seg_ctl_lo (seg_ctl_lo),
    .seg_ctl_hi (seg_ctl_hi),
    .bios_ctl   (bios_ctl),
    .reloc_mode (reloc_mode),
    .reloc_size (reloc_w)
  );

  assign rd_route   = rd_sel;
  assign wr_route   = wr_sel;
  assign reloc_size = reloc_w;

  always_comb begin
    if (!$isunknown({slot_hit, rd_sel, wr_sel})) begin
      // R11
      read_never_blocked_chk: assert (rd_sel != ROUTE_BLOCKED);
      // R1
      outside_dram_chk: assert ((|slot_hit) || (rd_sel == ROUTE_DRAM && wr_sel == ROUTE_DRAM));
    end
  end
endmodule

// File: tb/tb_shadow_route_decoder.sv
`timescale 1ns/1ps
module tb_shadow_route_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  seg_ctl_lo = '0, seg_ctl_hi = '0;
  logic [3:0]  bios_ctl = '0, rom_sel = '0;
  logic [2:0]  wr_lock = '0;
  logic [1:0]  reloc_mode = '0;
  logic [1:0]  rd_route, wr_route, reloc_size;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shadow_route_decoder #(.ADDR_W(24)) dut (
    .addr(addr), .seg_ctl_lo(seg_ctl_lo), .seg_ctl_hi(seg_ctl_hi),
    .bios_ctl(bios_ctl), .rom_sel(rom_sel), .wr_lock(wr_lock),
    .reloc_mode(reloc_mode), .rd_route(rd_route), .wr_route(wr_route),
    .reloc_size(reloc_size)
  );

  // Reference routes from the requirement text, codes: 0 dram, 1 rom, 2 ext, 3 blocked
  function automatic void model(input logic [23:0] a, output logic [1:0] er, output logic [1:0] ew);
    logic sw, sr, lk, rm;
    int seg;
    logic [7:0] pr;
    if (a < 24'hC0000 || a > 24'hFFFFF) begin er = 0; ew = 0; return; end
    if (a < 24'hE0000) begin
      seg = int'((a - 24'hC0000) / 24'h4000);
      pr  = (seg < 4) ? seg_ctl_lo : seg_ctl_hi;
      sw  = pr[(seg % 4) * 2];
      sr  = pr[(seg % 4) * 2 + 1];
      lk  = (seg < 2) && wr_lock[2];
      rm  = (seg < 2) ? rom_sel[2] : (seg < 4) ? rom_sel[3] : 1'b0;
    end else if (a < 24'hF0000) begin
      sw = bios_ctl[2]; sr = bios_ctl[3]; lk = wr_lock[0];
      rm = (a < 24'hE8000) ? rom_sel[0] : rom_sel[1];
    end else begin
      sw = bios_ctl[0]; sr = bios_ctl[1]; lk = wr_lock[1]; rm = 1'b0;
    end
    er = sr ? 2'd0 : (rm ? 2'd1 : 2'd2);
    ew = lk ? 2'd3 : sw ? 2'd0 : (rm ? 2'd1 : 2'd2);
  endfunction

  function automatic logic [1:0] reloc_model();
    if (reloc_mode == 2 && seg_ctl_hi == 0 && bios_ctl == 0) return 2'd1;
    if (reloc_mode == 3 && seg_ctl_hi == 0 && bios_ctl == 0 && seg_ctl_lo == 0) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%0d expected=%0d", tag, addr, act, exp);
    end
  endtask

  task automatic probe(input string tag, input logic [23:0] a);
    logic [1:0] er, ew;
    addr = a;
    #1;
    model(a, er, ew);
    check({tag, " rd"}, rd_route, er);
    check({tag, " wr"}, wr_route, ew);
  endtask

  task automatic set_cfg(input logic [7:0] lo, hi, input logic [3:0] b, r,
                         input logic [2:0] l, input logic [1:0] m);
    seg_ctl_lo = lo; seg_ctl_hi = hi; bios_ctl = b; rom_sel = r; wr_lock = l; reloc_mode = m;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset-state style: all fields zero -> external routes, no relocation
    set_cfg(8'h00, 8'h00, 4'h0, 4'h0, 3'b000, 2'd0);
    addr = 24'hC0000; #1;
    check("R3 zero cfg rd", rd_route, 2'd2);
    check("R3 zero cfg wr", wr_route, 2'd2);
    check("R10 zero mode", reloc_size, 2'd0);

    // R1: outside the window
    set_cfg(8'hFF, 8'hFF, 4'hF, 4'hF, 3'b111, 2'd0);
    addr = 24'hBFFFF; #1; check("R1 below rd", rd_route, 2'd0); check("R1 below wr", wr_route, 2'd0);
    addr = 24'h100000; #1; check("R1 above rd", rd_route, 2'd0); check("R1 above wr", wr_route, 2'd0);

    // R4: lock beats shadow write, reads intact
    set_cfg(8'h03, 8'h00, 4'h0, 4'h0, 3'b100, 2'd0);
    addr = 24'hC1000; #1; check("R4 lock wr", wr_route, 2'd3); check("R4 lock rd", rd_route, 2'd0);
    addr = 24'hC8000; #1; check("R5 no lock at C8", wr_route, 2'd2);

    // R2: pair bits, write even read odd (segment 5 -> seg_ctl_hi bits 3:2)
    set_cfg(8'h00, 8'h04, 4'h0, 4'h0, 3'b000, 2'd0);
    addr = 24'hD4000; #1; check("R2 seg5 wr", wr_route, 2'd0); check("R2 seg5 rd", rd_route, 2'd2);
    check("R6 seg5 rd ext", rd_route, 2'd2);

    // R3 / R5 / R7 ROM selects
    set_cfg(8'h00, 8'h00, 4'h0, 4'b1001, 3'b000, 2'd0);
    addr = 24'hC4000; #1; check("R3 rom C0", rd_route, 2'd2);
    addr = 24'hCC000; #1; check("R5 rom C8", rd_route, 2'd1);
    addr = 24'hE0000; #1; check("R7 rom E0", wr_route, 2'd1);
    addr = 24'hE8000; #1; check("R7 rom E8 off", wr_route, 2'd2);

    // R8 / R9: F region shadow and locks
    set_cfg(8'h00, 8'h00, 4'b0011, 4'hF, 3'b010, 2'd0);
    addr = 24'hFFFF0; #1; check("R8 F rd", rd_route, 2'd0); check("R9 F lock", wr_route, 2'd3);
    addr = 24'hEFFFF; #1; check("R9 E unlocked", wr_route, 2'd1); check("R11 rd", rd_route, 2'd1);

    // R10 relocation cases
    set_cfg(8'h01, 8'h00, 4'h0, 4'h0, 3'b000, 2'd2); check("R10 256 lo ok", reloc_size, 2'd1);
    set_cfg(8'h01, 8'h00, 4'h0, 4'h0, 3'b000, 2'd3); check("R10 384 lo deny", reloc_size, 2'd0);
    set_cfg(8'h00, 8'h00, 4'h0, 4'h0, 3'b000, 2'd3); check("R10 384 ok", reloc_size, 2'd2);
    set_cfg(8'h00, 8'h80, 4'h0, 4'h0, 3'b000, 2'd2); check("R10 256 hi deny", reloc_size, 2'd0);
    set_cfg(8'h00, 8'h00, 4'h1, 4'h0, 3'b000, 2'd2); check("R10 256 bios deny", reloc_size, 2'd0);
    set_cfg(8'h00, 8'h00, 4'h0, 4'h0, 3'b000, 2'd1); check("R10 mode1 none", reloc_size, 2'd0);

    // sweep: pseudo-random configurations across every 16 KB block
    lfsr = 32'h1ACE_B00C;
    for (int c = 0; c < 400; c++) begin
      logic [31:0] r2;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r2 = lfsr * 32'h9E3779B1;
      set_cfg(lfsr[7:0], (c % 3 == 0) ? 8'h00 : lfsr[15:8],
              (c % 3 == 0) ? 4'h0 : r2[3:0], r2[7:4], r2[10:8], r2[12:11]);
      if (c % 6 == 0) begin seg_ctl_lo = 8'h00; #1; end
      check("R10 sweep", reloc_size, reloc_model());
      for (int b = 0; b < 24; b++) begin
        logic [23:0] base;
        base = 24'hB0000 + 24'(b) * 24'h4000;
        probe("R2 R7 sweep start", base);
        probe("R3 R8 sweep end", base + 24'h3FFF);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule